// File: doc/BRIEF.md
# Door-Protected Nibble Settings Store

This block is the battery-backed settings memory of a pinball game controller: 256 locations of four bits each, seen by an 8-bit processor in the window 0x0100 to 0x01FF. The address decoder outside the block raises `cpu_sel` for that window and passes the low eight address bits as `cpu_addr`. A processor read returns the stored nibble in the low four data bits with the upper four bits driven high. A processor write keeps only the low nibble of the data.

The upper half of the array holds the operator settings and is guarded by the coin door. The active-low `prot_n` input comes from the door switch. While the door is closed (`prot_n` low), processor writes to offsets with address bit 7 set are dropped without any error indication. Writes to the lower half, which holds the audit counters, always land. Game code can therefore test the door state by reading a guarded location, writing a changed value and reading it back.

A second port lets an external controller restore the whole array from non-volatile storage before the processor starts, and dump it again later. While that port is enabled it owns the array, ignores the door, and holds off all processor accesses.

Top module: `settings_nibble_ram`

## Requirements
- R1: A processor write (`cpu_sel`=1, `cpu_we`=1) to an offset with bit 7 = 0 (0x00..0x7F) stores the low data nibble whatever the level of `prot_n`.
- R2: A processor write to an offset with bit 7 = 1 (0x80..0xFF) stores the low data nibble when `prot_n` = 1 (door open).
- R3: A processor write to an offset with bit 7 = 1 while `prot_n` = 0 is dropped: the stored nibble is left exactly as it was and no other output changes.
- R4: A processor read (`cpu_sel`=1, `cpu_we`=0) presents `cpu_rdata` = {4'hF, nibble} after the next rising clock edge, and `cpu_rdata` then holds until the next accepted processor read.
- R5: Bits 7:4 of `cpu_wdata` are never stored. `cpu_rdata[7:4]` is always 4'hF.
- R6: With `ld_en`=1 and `ld_we`=1, `ld_wdata` is stored at `ld_addr` at any offset and at any level of `prot_n`.
- R7: While `ld_en`=1 the processor side is ignored: no processor write lands, `cpu_rdata` does not change, and `cpu_hold` is 1. `cpu_hold` equals `ld_en` at all times.
- R8: With `ld_en`=1 and `ld_we`=0, `ld_rdata` presents the nibble at `ld_addr` after the next rising edge and holds it otherwise.
- R9: After reset, `cpu_rdata` is 8'hF0 and `ld_rdata` is 4'h0. Reset does not clear the array.
- R10: A read, a write of the incremented value and a second read at one guarded offset return equal data while `prot_n` = 0, and different data while `prot_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| prot_n | input | 1 | Door switch, low = closed = upper half guarded |
| cpu_sel | input | 1 | Processor access to the settings window in this cycle |
| cpu_we | input | 1 | 1 = processor write, 0 = processor read |
| cpu_addr | input | 8 | Offset in the window (0x00..0xFF) |
| cpu_wdata | input | 8 | Processor write data; only bits 3:0 are used |
| cpu_rdata | output | 8 | Registered read data, upper nibble all ones |
| ld_en | input | 1 | Load/dump port owns the array |
| ld_we | input | 1 | 1 = load write, 0 = dump read |
| ld_addr | input | 8 | Load/dump offset |
| ld_wdata | input | 4 | Nibble to store |
| ld_rdata | output | 4 | Registered dump data |
| cpu_hold | output | 1 | Processor access is being held off |

## Verification
The processor writes are tried at both ends of each half (0x00, 0x7F, 0x80, 0xFF) with the door both open and closed. This separates a decoder that looks at bit 7 from one that guards the wrong range or ignores the door. A read, increment and read-back on a guarded location shows that a dropped write leaves the old nibble in place rather than corrupting it. Writes with non-zero upper data bits show that only the low nibble is kept. Load-port writes with the door closed, and processor traffic issued while the load port is enabled, show that the two ports are arbitrated as specified. Sampling just before and just after the capturing edge pins the one-cycle read latency.

// File: rtl/snm_pkg.sv
package snm_pkg;
    // Kind of access granted to the array in one cycle
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_CPU_RD  = 3'd1,
        ACC_CPU_WR  = 3'd2,
        ACC_CPU_BLK = 3'd3,   // processor write dropped by the door guard
        ACC_LD_RD   = 3'd4,
        ACC_LD_WR   = 3'd5
    } acc_e;

    function automatic logic acc_is_write(input acc_e a);
        return (a == ACC_CPU_WR) || (a == ACC_LD_WR);
    endfunction
endpackage

// File: rtl/snm_arbiter.sv
// Chooses which port owns the array and applies the door guard.
module snm_arbiter
    import snm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 8,
    parameter int NIB_W  = 4
) (
    input  logic              prot_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    input  logic              ld_en,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [NIB_W-1:0]  ld_wdata,
    output acc_e              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [NIB_W-1:0]  acc_nib,
    output logic              cpu_hold
);
    localparam int GUARD_BIT = ADDR_W - 1;

    logic guarded_d;
    logic unused_hi_bits;

    assign unused_hi_bits = ^cpu_wdata[BUS_W-1:NIB_W];

    always_comb begin
        acc       = ACC_IDLE;
        acc_addr  = cpu_addr;
        acc_nib   = cpu_wdata[NIB_W-1:0];
        cpu_hold  = ld_en;
        guarded_d = cpu_addr[GUARD_BIT] && !prot_n;
        if (ld_en) begin
            acc_addr = ld_addr;
            acc_nib  = ld_wdata;
            acc      = ld_we ? ACC_LD_WR : ACC_LD_RD;
        end else if (cpu_sel) begin
            if (!cpu_we)        acc = ACC_CPU_RD;
            else if (guarded_d) acc = ACC_CPU_BLK;
            else                acc = ACC_CPU_WR;
        end
    end
endmodule

// File: rtl/snm_array.sv
// Nibble storage with registered read paths for each port.
module snm_array
    import snm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [NIB_W-1:0]  acc_nib,
    output logic [NIB_W-1:0]  cpu_nib,
    output logic [NIB_W-1:0]  ld_nib
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [NIB_W-1:0] cpu_nib;
        logic [NIB_W-1:0] ld_nib;
    } rd_st_t;

    logic [NIB_W-1:0] mem_q [DEPTH];
    rd_st_t           rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        case (acc)
            ACC_CPU_RD: rd_d.cpu_nib = mem_q[acc_addr];
            ACC_LD_RD:  rd_d.ld_nib  = mem_q[acc_addr];
            default:    rd_d = rd_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Battery-backed contents: kept across reset
    always_ff @(posedge clk) begin
        if (acc_is_write(acc)) mem_q[acc_addr] <= acc_nib;
    end

    assign cpu_nib = rd_q.cpu_nib;
    assign ld_nib  = rd_q.ld_nib;
endmodule

// File: rtl/snm_rd_fmt.sv
// Widens the stored nibble to the processor bus with the unused bits high.
module snm_rd_fmt #(
    parameter int BUS_W = 8,
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] nib,
    output logic [BUS_W-1:0] bus
);
    localparam int PAD_W = BUS_W - NIB_W;

    always_comb bus = {{PAD_W{1'b1}}, nib};
endmodule

// File: rtl/settings_nibble_ram.sv
module settings_nibble_ram
    import snm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic [BUS_W-1:0]  cpu_rdata,
    input  logic              ld_en,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [NIB_W-1:0]  ld_wdata,
    output logic [NIB_W-1:0]  ld_rdata,
    output logic              cpu_hold
);
    acc_e              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [NIB_W-1:0]  acc_nib;
    logic [NIB_W-1:0]  cpu_nib;

    snm_arbiter #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .NIB_W(NIB_W)) u_arb (
        .prot_n    (prot_n),
        .cpu_sel   (cpu_sel),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .ld_en     (ld_en),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_wdata  (ld_wdata),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .acc_nib   (acc_nib),
        .cpu_hold  (cpu_hold)
    );

    snm_array #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .acc_addr (acc_addr),
        .acc_nib  (acc_nib),
        .cpu_nib  (cpu_nib),
        .ld_nib   (ld_rdata)
    );

    snm_rd_fmt #(.BUS_W(BUS_W), .NIB_W(NIB_W)) u_fmt (
        .nib (cpu_nib),
        .bus (cpu_rdata)
    );
endmodule

// File: rtl/snm_checker.sv
module snm_checker
    import snm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 8,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              ld_en,
    input logic              ld_we,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [BUS_W-1:0]  cpu_rdata,
    input logic [NIB_W-1:0]  ld_rdata,
    input logic              cpu_hold,
    input acc_e              acc,
    input logic [ADDR_W-1:0] acc_addr
);
    localparam int GUARD_BIT = ADDR_W - 1;

    // R1: lower-half processor writes always reach the array
    a_r1_low_half_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_we && !ld_en && !cpu_addr[GUARD_BIT]) |-> acc_is_write(acc));

    // R2: upper-half processor writes reach the array with the door open
    a_r2_open_door_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_we && !ld_en && prot_n) |-> acc_is_write(acc));

    // R3: guarded writes never reach the array
    a_r3_guard_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_we && !ld_en && cpu_addr[GUARD_BIT] && !prot_n) |-> !acc_is_write(acc));

    // R5: upper bus bits of read data stay high
    a_r5_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[BUS_W-1:NIB_W] == '1);

    // R4: processor read data only moves after an accepted read
    a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && !cpu_we && !ld_en) |=> $stable(cpu_rdata));

    // R6: load writes go to the load address
    a_r6_load_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_we) |-> (acc == ACC_LD_WR && acc_addr == ld_addr));

    // R7: hold flag tracks the load port
    a_r7_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold == ld_en);

    // R8: dump data only moves after a dump read
    a_r8_dump_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && !ld_we) |=> $stable(ld_rdata));
endmodule

bind settings_nibble_ram snm_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .NIB_W(NIB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_n    (prot_n),
    .cpu_sel   (cpu_sel),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .ld_en     (ld_en),
    .ld_we     (ld_we),
    .ld_addr   (ld_addr),
    .cpu_rdata (cpu_rdata),
    .ld_rdata  (ld_rdata),
    .cpu_hold  (cpu_hold),
    .acc       (acc),
    .acc_addr  (acc_addr)
);

// File: tb/tb_settings_nibble_ram.sv
module tb_settings_nibble_ram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_n = 1'b1;
    logic       cpu_sel = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ld_en = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [3:0] ld_wdata = '0;
    logic [3:0] ld_rdata;
    logic       cpu_hold;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    settings_nibble_ram dut (
        .clk(clk), .rst_n(rst_n), .prot_n(prot_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ld_en(ld_en), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .cpu_hold(cpu_hold)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; results sampled at the next falling edge
    task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_sel = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic ld_write(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_we = 1'b1; ld_addr = a; ld_wdata = d;
        @(negedge clk);
        ld_en = 1'b0; ld_we = 1'b0;
    endtask

    task automatic ld_read(input logic [7:0] a, output logic [3:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_we = 1'b0; ld_addr = a;
        @(negedge clk);
        ld_en = 1'b0;
        d = ld_rdata;
    endtask

    task automatic t_reset;
        chk("R9 cpu_rdata after reset", cpu_rdata, 8'hF0);
        chk("R9 ld_rdata after reset", {4'h0, ld_rdata}, 8'h00);
        chk("R7 cpu_hold idle", {7'h0, cpu_hold}, 8'h00);
    endtask

    task automatic t_low_half;
        logic [7:0] r;
        prot_n = 1'b0;
        cpu_write(8'h00, 8'h0A); cpu_read(8'h00, r); chk("R1 low write 0x00 door closed", r, 8'hFA);
        cpu_write(8'h7F, 8'h05); cpu_read(8'h7F, r); chk("R1 low write 0x7F door closed", r, 8'hF5);
        prot_n = 1'b1;
        cpu_write(8'h10, 8'h0C); cpu_read(8'h10, r); chk("R1 low write 0x10 door open", r, 8'hFC);
    endtask

    task automatic t_upper_open;
        logic [7:0] r;
        prot_n = 1'b1;
        cpu_write(8'h80, 8'h03); cpu_read(8'h80, r); chk("R2 upper write 0x80", r, 8'hF3);
        cpu_write(8'hFF, 8'h0C); cpu_read(8'hFF, r); chk("R2 upper write 0xFF", r, 8'hFC);
    endtask

    task automatic t_upper_guarded;
        logic [7:0] r;
        prot_n = 1'b1;
        cpu_write(8'h90, 8'h06);
        prot_n = 1'b0;
        cpu_write(8'h90, 8'h09); cpu_read(8'h90, r); chk("R3 guarded write 0x90 dropped", r, 8'hF6);
        cpu_write(8'hFF, 8'h01); cpu_read(8'hFF, r); chk("R3 guarded write 0xFF dropped", r, 8'hFC);
        cpu_write(8'h80, 8'h0E); cpu_read(8'h80, r); chk("R3 guarded write 0x80 dropped", r, 8'hF3);
    endtask

    task automatic t_probe;
        logic [7:0] a, b;
        prot_n = 1'b1;
        cpu_write(8'hBB, 8'h04);
        prot_n = 1'b0;
        cpu_read(8'hBB, a); cpu_write(8'hBB, a + 8'h01); cpu_read(8'hBB, b);
        chk("R10 probe door closed equal", b, a);
        prot_n = 1'b1;
        cpu_read(8'hBB, a); cpu_write(8'hBB, a + 8'h01); cpu_read(8'hBB, b);
        chk("R10 probe door open changed", b, 8'hF5);
    endtask

    task automatic t_wdata_hi;
        logic [7:0] r;
        prot_n = 1'b1;
        cpu_write(8'h22, 8'hA7); cpu_read(8'h22, r); chk("R5 upper write bits ignored", r, 8'hF7);
        cpu_write(8'h23, 8'h50); cpu_read(8'h23, r); chk("R5 zero nibble reads F0", r, 8'hF0);
    endtask

    task automatic t_latency;
        logic [7:0] r;
        cpu_read(8'h22, r);                   // cpu_rdata now F7
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h10;
        @(posedge clk); #1;
        chk("R4 new data right after edge", cpu_rdata, 8'hFC);
        @(negedge clk);
        cpu_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 data holds without read", cpu_rdata, 8'hFC);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h22;
        #1;
        chk("R4 old data before edge", cpu_rdata, 8'hFC);
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic t_load;
        logic [3:0] d;
        logic [7:0] r;
        prot_n = 1'b0;
        ld_write(8'hC0, 4'hE);
        ld_read(8'hC0, d); chk("R8 dump of loaded 0xC0", {4'h0, d}, 8'h0E);
        cpu_read(8'hC0, r); chk("R6 load ignores door", r, 8'hFE);
        ld_read(8'h00, d); chk("R8 dump of processor data 0x00", {4'h0, d}, 8'h0A);
        repeat (2) @(negedge clk);
        chk("R8 dump data holds", {4'h0, ld_rdata}, 8'h0A);
    endtask

    task automatic t_hold;
        logic [7:0] r;
        prot_n = 1'b1;
        cpu_write(8'h11, 8'h01);
        cpu_read(8'h22, r);                   // cpu_rdata = F7
        @(negedge clk);
        ld_en = 1'b1; ld_we = 1'b0; ld_addr = 8'h05;
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h11; cpu_wdata = 8'h03;
        #1;
        chk("R7 cpu_hold during load", {7'h0, cpu_hold}, 8'h01);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 8'h10;      // read attempt during load
        @(negedge clk);
        chk("R7 cpu_rdata unchanged during load", cpu_rdata, 8'hF7);
        ld_en = 1'b0; cpu_sel = 1'b0;
        #1;
        chk("R7 cpu_hold released", {7'h0, cpu_hold}, 8'h00);
        cpu_read(8'h11, r); chk("R7 held write not stored", r, 8'hF1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_half();
        t_upper_open();
        t_upper_guarded();
        t_probe();
        t_wdata_hi();
        t_latency();
        t_load();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule